// File: doc/BRIEF.md
# Prescaled Down-Counting Watchdog Timer

This block is a watchdog peripheral that sits on a simple register bus: one write strobe, an address, 32-bit write data and read data that depends only on the current address. It holds three registers: a control word, a 16-bit reload value and the live 16-bit count. The clock first goes through a programmable prescaler whose field holds the divisor minus one. A fixed divider then divides by 16, 32, 64 or 128, and each resulting tick moves the count down by one.

When a tick takes the count from one to zero, the block emits a one-cycle interrupt pulse, a one-cycle reset-request pulse, or both. Each pulse has its own enable bit in the control word. On the next tick the count reloads from the reload register and the cycle starts again. Software keeps the system alive by writing the count register before it runs out. Any write to the control word restarts the prescaler and the fixed divider from zero, so a new setting always begins on a clean tick boundary.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0x0000_8039 (prescaler 0x80, divider code 3, run 1, interrupt enable 0, reset enable 1), the reload and count registers both read 0x0000_8000, and irq and rst_req are low.
- R2: The control word is at byte offset 0x00, the reload value at 0x04 and the count at 0x08. Any other address reads zero. The control word keeps only bits 15:8, 5, 4:3, 2 and 0 (write mask 0x0000_FF3D). The reload and count registers keep the low 16 bits of a write and read back zero-extended.
- R3: While running, the count drops by one every (PRE+1)*(16<<DIV) clock cycles, where PRE is control bits 15:8 and DIV is control bits 4:3 (codes 0 to 3 select 16, 32, 64 and 128). The first drop lands that many cycles after the control write.
- R4: While the run bit (control bit 5) is clear, the count holds its value and neither output pulses.
- R5: A write to the count register loads the written value on that clock edge. It takes precedence over a decrement due on the same edge, and rewriting the count before it reaches zero prevents any expiry.
- R6: When a tick takes the count from 1 to 0, the count reads 0 in the following cycle and the enabled outputs pulse in that same cycle.
- R7: The irq pulse appears only if control bit 2 is set, and the rst_req pulse appears only if control bit 0 is set. The two enables are independent.
- R8: The tick that finds the count at zero loads the reload value into the count.
- R9: Any write to the control word clears the prescaler and divider state, so the next decrement comes a full period after that write.
- R10: irq and rst_req are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | 1 | One-cycle expiry interrupt pulse |
| rst_req | output | 1 | One-cycle expiry reset-request pulse |

## Verification
The hardest situation to reach from the ports is a count write that lands on the exact edge where a decrement is due. From the ports alone the bench cannot see when the prescaler and divider are about to wrap. The bench therefore writes the control word to put both stages at a known zero point, counts whole periods from that edge, and times the keepalive write to meet the tick edge exactly. A second case rewrites the control word partway through a period and confirms that the old phase is discarded. Randomized runs then vary prescaler, divider, start count, reload value and both enables, and check the decrement, expiry and reload edges computed from the period formula.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // register byte offsets
   localparam int OFS_CTRL   = 0;
   localparam int OFS_RELOAD = 4;
   localparam int OFS_COUNT  = 8;

   // control word field positions
   localparam int BIT_RST_EN = 0;
   localparam int BIT_IRQ_EN = 2;
   localparam int DIV_LSB    = 3;
   localparam int DIV_SEL_W  = 2;
   localparam int BIT_RUN    = 5;
   localparam int PRE_LSB    = 8;

   typedef struct packed {
      logic                 run;
      logic [DIV_SEL_W-1:0] div_sel;
      logic                 irq_en;
      logic                 rst_en;
   } mode_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int CNT_W      = 16,
   parameter int PRE_W      = 8,
   parameter int RST_PRE    = 128,
   parameter int RST_DIV    = 3,
   parameter bit RST_RUN    = 1'b1,
   parameter bit RST_IRQ_EN = 1'b0,
   parameter bit RST_RST_EN = 1'b1,
   parameter int RST_RELOAD = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt_val,
   output mode_t             mode,
   output logic [PRE_W-1:0]  pre_val,
   output logic [CNT_W-1:0]  reload_val,
   output logic              ctrl_wr,
   output logic              cnt_wr,
   output logic [CNT_W-1:0]  cnt_wr_val
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);

   logic              reload_wr;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] reload_word;
   logic [DATA_W-1:0] cnt_word;
   mode_t             mode_q;
   logic [PRE_W-1:0]  pre_q;
   logic [CNT_W-1:0]  reload_q;

   assign ctrl_wr    = bus_we && (bus_addr == A_CTRL);
   assign reload_wr  = bus_we && (bus_addr == A_RELOAD);
   assign cnt_wr     = bus_we && (bus_addr == A_COUNT);
   assign cnt_wr_val = bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q.run     <= RST_RUN;
         mode_q.div_sel <= DIV_SEL_W'(RST_DIV);
         mode_q.irq_en  <= RST_IRQ_EN;
         mode_q.rst_en  <= RST_RST_EN;
         pre_q          <= PRE_W'(RST_PRE);
      end else if (ctrl_wr) begin
         mode_q.run     <= bus_wdata[BIT_RUN];
         mode_q.div_sel <= bus_wdata[DIV_LSB +: DIV_SEL_W];
         mode_q.irq_en  <= bus_wdata[BIT_IRQ_EN];
         mode_q.rst_en  <= bus_wdata[BIT_RST_EN];
         pre_q          <= bus_wdata[PRE_LSB +: PRE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload_q <= CNT_W'(RST_RELOAD);
      else if (reload_wr) reload_q <= bus_wdata[CNT_W-1:0];
   end

   assign mode       = mode_q;
   assign pre_val    = pre_q;
   assign reload_val = reload_q;

   always_comb begin
      ctrl_word                         = '0;
      ctrl_word[PRE_LSB +: PRE_W]       = pre_q;
      ctrl_word[BIT_RUN]                = mode_q.run;
      ctrl_word[DIV_LSB +: DIV_SEL_W]   = mode_q.div_sel;
      ctrl_word[BIT_IRQ_EN]             = mode_q.irq_en;
      ctrl_word[BIT_RST_EN]             = mode_q.rst_en;
   end

   // zero extension of the 16-bit registers; variant picked by width
   if (CNT_W < DATA_W) begin : g_pad
      assign reload_word = {{(DATA_W-CNT_W){1'b0}}, reload_q};
      assign cnt_word    = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
   end else begin : g_nopad
      assign reload_word = reload_q;
      assign cnt_word    = cnt_val;
   end

   always_comb begin
      unique case (bus_addr)
         A_CTRL:   bus_rdata = ctrl_word;
         A_RELOAD: bus_rdata = reload_word;
         A_COUNT:  bus_rdata = cnt_word;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
   parameter int PRE_W         = 8,
   parameter int DIV_BASE_LOG2 = 4,
   parameter int DIV_SEL_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 restart,
   input  logic [PRE_W-1:0]     pre_val,
   input  logic [DIV_SEL_W-1:0] div_sel,
   output logic                 tick
);
   localparam int NUM_SEL   = 1 << DIV_SEL_W;
   localparam int DIV_CNT_W = DIV_BASE_LOG2 + NUM_SEL - 1;

   logic [PRE_W-1:0]     pre_cnt;
   logic [DIV_CNT_W-1:0] div_cnt;
   logic [DIV_CNT_W-1:0] div_term [NUM_SEL];
   logic                 pre_hit;
   logic                 div_hit;

   // terminal value of the fixed divider for every selection code
   for (genvar i = 0; i < NUM_SEL; i++) begin : g_term
      assign div_term[i] = DIV_CNT_W'((1 << (DIV_BASE_LOG2 + i)) - 1);
   end

   assign pre_hit = run && (pre_cnt == pre_val);
   assign div_hit = (div_cnt == div_term[div_sel]);
   assign tick    = pre_hit && div_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_cnt <= '0;
      else if (restart || !run)  pre_cnt <= '0;
      else if (pre_hit)          pre_cnt <= '0;
      else                       pre_cnt <= pre_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_cnt <= '0;
      else if (restart || !run)  div_cnt <= '0;
      else if (pre_hit) begin
         if (div_hit) div_cnt <= '0;
         else         div_cnt <= div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CNT_W     = 16,
   parameter int RST_COUNT = 32768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             irq_en,
   input  logic             rst_en,
   output logic [CNT_W-1:0] cnt,
   output logic             irq,
   output logic             rst_req
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             rst_q;
   logic             expire;

   // a tick that moves the count from one to zero, unless software reloads
   assign expire = tick && !load && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RST_COUNT);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         if (cnt_q == '0) cnt_q <= reload_val;
         else             cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         irq_q <= expire && irq_en;
         rst_q <= expire && rst_en;
      end
   end

   assign cnt     = cnt_q;
   assign irq     = irq_q;
   assign rst_req = rst_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 4,
   parameter int CNT_W         = 16,
   parameter int PRE_W         = 8,
   parameter int DIV_BASE_LOG2 = 4,
   parameter int RST_PRE       = 128,
   parameter int RST_DIV       = 3,
   parameter bit RST_RUN       = 1'b1,
   parameter bit RST_IRQ_EN    = 1'b0,
   parameter bit RST_RST_EN    = 1'b1,
   parameter int RST_RELOAD    = 32768,
   parameter int RST_COUNT     = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              rst_req
);
   // elaboration-time parameter checks
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must not exceed DATA_W");
   end
   if (PRE_LSB + PRE_W > DATA_W) begin : g_bad_pre
      $error("prescaler field does not fit the control word");
   end
   if ((1 << ADDR_W) <= OFS_COUNT) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end
   if (DIV_BASE_LOG2 + (1 << DIV_SEL_W) - 1 > 30) begin : g_bad_div
      $error("fixed divider too wide");
   end
   if (RST_DIV >= (1 << DIV_SEL_W)) begin : g_bad_rdiv
      $error("RST_DIV out of range");
   end

   mode_t            mode;
   logic [PRE_W-1:0] pre_val;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] cnt_val;
   logic [CNT_W-1:0] cnt_wr_val;
   logic             ctrl_wr;
   logic             cnt_wr;
   logic             tick;

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W),
      .RST_PRE(RST_PRE), .RST_DIV(RST_DIV), .RST_RUN(RST_RUN),
      .RST_IRQ_EN(RST_IRQ_EN), .RST_RST_EN(RST_RST_EN),
      .RST_RELOAD(RST_RELOAD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
      .mode(mode), .pre_val(pre_val), .reload_val(reload_val),
      .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .cnt_wr_val(cnt_wr_val)
   );

   wdog_tick_gen #(
      .PRE_W(PRE_W), .DIV_BASE_LOG2(DIV_BASE_LOG2), .DIV_SEL_W(DIV_SEL_W)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .run(mode.run), .restart(ctrl_wr),
      .pre_val(pre_val), .div_sel(mode.div_sel), .tick(tick)
   );

   wdog_count #(
      .CNT_W(CNT_W), .RST_COUNT(RST_COUNT)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr),
      .load_val(cnt_wr_val), .reload_val(reload_val),
      .irq_en(mode.irq_en), .rst_en(mode.rst_en),
      .cnt(cnt_val), .irq(irq), .rst_req(rst_req)
   );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              run,
   input logic              irq_en,
   input logic              rst_en,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  reload,
   input logic              irq,
   input logic              rst_req
);
   logic wr_cnt;
   assign wr_cnt = bus_we && (bus_addr == ADDR_W'(wdog_pkg::OFS_COUNT));

   // R5
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

   // R4
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(cnt));

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == '0 && !wr_cnt) |=> (cnt == $past(reload)));

   // R6
   expiry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq || rst_req) |-> (cnt == '0));

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irq_en));

   // R7
   rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(rst_en));

   // R10
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
endmodule

bind wdog_timer wdog_timer_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .run(mode.run), .irq_en(mode.irq_en),
   .rst_en(mode.rst_en), .tick(tick), .cnt(cnt_val), .reload(reload_val),
   .irq(irq), .rst_req(rst_req)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
   localparam int A_CTRL = 0, A_RELOAD = 4, A_COUNT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = 4'(A_COUNT);
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, rst_req;

   int total = 0;
   int bad = 0;
   int t = 0;
   int irq_seen = 0;
   int rst_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdog_timer u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .rst_req(rst_req)
   );

   always @(negedge clk) begin
      if (irq)     irq_seen++;
      if (rst_req) rst_seen++;
   end

   function automatic int period(int pre, int sel);
      return (pre + 1) * (16 << sel);
   endfunction

   function automatic logic [31:0] ctrl_word(int pre, int sel, bit run,
                                             bit ie, bit re);
      return (32'(pre) << 8) | (32'(run) << 5) | (32'(sel) << 3) |
             (32'(ie) << 2) | 32'(re);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(int addr, logic [31:0] data);
      @(negedge clk);
      bus_addr  = 4'(addr);
      bus_we    = 1'b1;
      bus_wdata = data;
      @(posedge clk);
      #1;
      bus_we    = 1'b0;
      bus_addr  = 4'(A_COUNT);
      t = 0;
   endtask

   task automatic rd(int addr, output logic [31:0] data);
      @(negedge clk);
      bus_addr = 4'(addr);
      #1;
      data = bus_rdata;
      bus_addr = 4'(A_COUNT);
   endtask

   // advance to 1 ns after edge k counted from the last write edge
   task automatic wait_to(int k);
      repeat (k - t) @(posedge clk);
      #1;
      t = k;
   endtask

   task automatic run_expiry(int pre, int sel, int n, bit ie, bit re,
                             int reload);
      int p;
      p = period(pre, sel);
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'(reload));
      wr(A_COUNT, 32'(n));
      wr(A_CTRL, ctrl_word(pre, sel, 1'b1, ie, re));
      wait_to(p - 1);
      chk("R3 count before first period", bus_rdata, 32'(n));
      if (n >= 2) begin
         wait_to(p);
         chk("R3 first decrement", bus_rdata, 32'(n - 1));
         wait_to(n * p - 1);
         chk("R6 count one before expiry", bus_rdata, 32'd1);
      end
      chk("R6 no irq before expiry", {31'b0, irq}, 32'd0);
      wait_to(n * p);
      chk("R6 count zero at expiry", bus_rdata, 32'd0);
      chk("R7 irq gated by bit 2", {31'b0, irq}, {31'b0, ie});
      chk("R7 rst_req gated by bit 0", {31'b0, rst_req}, {31'b0, re});
      wait_to(n * p + 1);
      chk("R10 irq single cycle", {31'b0, irq}, 32'd0);
      chk("R10 rst_req single cycle", {31'b0, rst_req}, 32'd0);
      wait_to((n + 1) * p - 1);
      chk("R8 zero held until next tick", bus_rdata, 32'd0);
      wait_to((n + 1) * p);
      chk("R8 reload on tick at zero", bus_rdata, 32'(reload));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int i0, i1;
      process::self().srandom(32'd1234);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, v);   chk("R1 ctrl reset", v, 32'h0000_8039);
      rd(A_RELOAD, v); chk("R1 reload reset", v, 32'h0000_8000);
      rd(A_COUNT, v);  chk("R1 count reset", v, 32'h0000_8000);
      chk("R1 irq low", {31'b0, irq}, 32'd0);
      chk("R1 rst_req low", {31'b0, rst_req}, 32'd0);

      // R2 map and masks
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, v);   chk("R2 ctrl mask", v, 32'h0000_FF3D);
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'hABCD_1234);
      rd(A_RELOAD, v); chk("R2 reload low half", v, 32'h0000_1234);
      rd(12, v);       chk("R2 unused offset 0xC", v, 32'h0);
      rd(2, v);        chk("R2 unused offset 0x2", v, 32'h0);

      // directed expiries
      run_expiry(0, 0, 3, 1'b1, 1'b0, 5);
      run_expiry(1, 1, 2, 1'b0, 1'b1, 7);
      run_expiry(0, 3, 1, 1'b1, 1'b1, 2);
      run_expiry(2, 2, 2, 1'b1, 1'b1, 3);

      // randomized expiries
      for (int it = 0; it < 12; it++) begin
         run_expiry(int'($urandom_range(3, 0)), int'($urandom_range(2, 0)),
                    int'($urandom_range(5, 1)), 1'($urandom_range(1, 0)),
                    1'($urandom_range(1, 0)), int'($urandom_range(20, 1)));
      end

      // R4 halted counter
      wr(A_CTRL, 32'h0);
      wr(A_COUNT, 32'd2);
      i0 = irq_seen; i1 = rst_seen;
      wr(A_CTRL, ctrl_word(0, 0, 1'b0, 1'b1, 1'b1));
      wait_to(100);
      chk("R4 count held while stopped", bus_rdata, 32'd2);
      chk("R4 no irq while stopped", 32'(irq_seen - i0), 32'd0);
      chk("R4 no rst_req while stopped", 32'(rst_seen - i1), 32'd0);

      // R5 count write on the decrement edge
      wr(A_CTRL, 32'h0);
      wr(A_COUNT, 32'd6);
      wr(A_CTRL, ctrl_word(0, 0, 1'b1, 1'b0, 1'b0));
      wait_to(15);
      wr(A_COUNT, 32'd20);
      t = 16;
      chk("R5 write beats coincident decrement", bus_rdata, 32'd20);
      wait_to(31);
      chk("R5 loaded value held", bus_rdata, 32'd20);
      wait_to(32);
      chk("R5 decrement resumes", bus_rdata, 32'd19);

      // R9 control write restarts the prescaler
      wr(A_CTRL, 32'h0);
      wr(A_COUNT, 32'd10);
      wr(A_CTRL, ctrl_word(3, 0, 1'b1, 1'b0, 1'b0));
      wait_to(40);
      wr(A_CTRL, ctrl_word(3, 0, 1'b1, 1'b0, 1'b0));
      wait_to(63);
      chk("R9 old phase discarded", bus_rdata, 32'd10);
      wait_to(64);
      chk("R9 full period after write", bus_rdata, 32'd9);

      // R5 keepalive
      wr(A_CTRL, 32'h0);
      wr(A_COUNT, 32'd3);
      i0 = irq_seen; i1 = rst_seen;
      wr(A_CTRL, ctrl_word(0, 0, 1'b1, 1'b1, 1'b1));
      for (int k = 0; k < 8; k++) begin
         wait_to(30);
         wr(A_COUNT, 32'd3);
      end
      wait_to(20);
      chk("R5 keepalive no irq", 32'(irq_seen - i0), 32'd0);
      chk("R5 keepalive no rst_req", 32'(rst_seen - i1), 32'd0);
      chk("R5 keepalive count", bus_rdata, 32'd2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule